// File: doc/BRIEF.md
# Serial Peripheral Byte Shifter

A byte-wide full-duplex serial shifter that works either as bus master or as bus slave. As master it makes its own serial clock from the system clock. A bus write of the transmit byte starts a transfer. It shifts that byte out on its data output and collects the reply from its data input. As slave it follows an external serial clock. It is active only while the select input is held low, and only then does it drive its reply line.

Clock idle level, the edge that samples data, bit order and master rate are all control inputs. The block raises a completion flag when the eighth bit has been sampled. Software clears the flag with a status read followed by a data access. The slave-side clock, data and select inputs pass through two-stage synchronizers before use.

Top module: `spi_shift_unit`

## Requirements
- R1: A master transfer is full duplex. One byte goes out on `mosi_o` while eight bits are taken from `miso_i`, and the received byte then appears on `rd_data`.
- R2: With `lsb_first`=1 bit 0 is shifted first and bit 7 last. With `lsb_first`=0 bit 7 goes first. The same order applies to receive.
- R3: In master mode the serial clock is the system clock divided by 2^(rate+1) for `rate` 0..6, which gives ratios 2 to 128. `rate`=7 behaves as `rate`=6. From the write edge, the flag rises 15·2^rate cycles later when `cpha`=0 and 16·2^rate cycles later when `cpha`=1.
- R4: A write in master mode while idle starts a transfer. A write while a master transfer is running is ignored and leaves the outgoing byte unchanged.
- R5: `xfer_done` goes to 1 when the eighth bit of a byte has been sampled. It stays at 1 until it is cleared.
- R6: `xfer_done` clears only on a data access (`rd_en` or `wr_en`) that comes after a status read (`stat_rd`) which saw the flag set. A data access with no prior status read leaves the flag set.
- R7: When idle, the serial clock rests at `cpol`. With `cpha`=0 data is sampled on the leading edge and changed on the trailing edge. With `cpha`=1 data is changed on the leading edge and sampled on the trailing edge. `mosi_o` is stable at every sample edge.
- R8: In slave mode `miso_oe` is 1 only while `ss_n_i` is low, after a two-cycle synchronizer delay. During that time the slave shifts in `mosi_i` and presents its own byte on `miso_o`, in the same edge and order rules as R2 and R7.
- R9: In slave mode `rate` has no effect, and `busy_o` stays 0.
- R10: If `ss_n_i` rises before the eighth bit, the bit counter returns to zero. The partial byte sets no flag, and the next byte is received whole.
- R11: After reset `xfer_done`, `busy_o` and `miso_oe` are 0, `rd_data` is 0 and `sck_o` equals `cpol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| is_master | input | 1 | 1 = master, 0 = slave |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| lsb_first | input | 1 | 1 = bit 0 first, 0 = bit 7 first |
| rate | input | 3 | Master divider select, 2^(rate+1) |
| wr_en | input | 1 | Data write strobe |
| wr_data | input | 8 | Byte to transmit |
| stat_rd | input | 1 | Status read strobe |
| rd_en | input | 1 | Data read strobe |
| rd_data | output | 8 | Last received byte |
| xfer_done | output | 1 | Completion flag |
| busy_o | output | 1 | Master transfer in progress |
| sck_o | output | 1 | Master serial clock |
| mosi_o | output | 1 | Master data out |
| miso_i | input | 1 | Master data in |
| sck_i | input | 1 | Slave serial clock |
| mosi_i | input | 1 | Slave data in |
| ss_n_i | input | 1 | Slave select, active low |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Slave data out enable |

## Verification
In master mode the bench counts system cycles from the write edge until the flag appears. It expects exactly 15·2^rate or 16·2^rate cycles, depending on the sampling edge. It checks the received byte and the idle clock level once `busy_o` has dropped. Slave inputs pass three register stages before they act: two synchronizer stages and the edge register. The bench therefore holds each serial clock phase for eight system cycles. It checks `miso_o` just before each sample edge it drives, and it reads the flag eight cycles after the final edge. Flag clearing is checked one cycle after each strobe.

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int W        = 8,
  parameter int MAX_RATE = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         is_master,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         lsb_first,
  input  logic [2:0]   rate,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         stat_rd,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         xfer_done,
  output logic         busy_o,
  output logic         sck_o,
  output logic         mosi_o,
  input  logic         miso_i,
  input  logic         sck_i,
  input  logic         mosi_i,
  input  logic         ss_n_i,
  output logic         miso_o,
  output logic         miso_oe
);
  localparam int BW = $clog2(W);
  localparam int EW = $clog2(2 * W);
  localparam int HW = (MAX_RATE < 1) ? 1 : MAX_RATE;

  logic [W-1:0]  tx_q, rx_q, rd_q;
  logic [BW-1:0] bit_q;
  logic [EW-1:0] edge_q;
  logic [HW-1:0] hc_q;
  logic          busy_q, sck_q, flag_q, seen_q;
  logic [1:0]    sck_s, mosi_s, ss_s;
  logic          sck_d;

  logic [2:0]    rsel;
  logic [HW-1:0] half_m1;
  assign rsel    = (int'(rate) > MAX_RATE) ? 3'(MAX_RATE) : rate;
  assign half_m1 = (HW'(1) << rsel) - HW'(1);

  logic m_tick, m_lead, m_trail;
  assign m_tick  = busy_q && (hc_q == half_m1);
  assign m_lead  = m_tick && !edge_q[0];
  assign m_trail = m_tick && edge_q[0];

  logic slv_act, s_chg, s_lead, s_trail;
  assign slv_act = !is_master && !ss_s[1];
  assign s_chg   = slv_act && (sck_s[1] != sck_d);
  assign s_lead  = s_chg && (sck_d == cpol);
  assign s_trail = s_chg && (sck_d != cpol);

  logic lead, trail, samp, setup, din, last, start;
  assign lead  = is_master ? m_lead  : s_lead;
  assign trail = is_master ? m_trail : s_trail;
  assign samp  = cpha ? trail : lead;
  assign setup = cpha ? lead  : trail;
  assign din   = is_master ? miso_i : mosi_s[1];
  assign last  = samp && (bit_q == BW'(W - 1));
  assign start = is_master && wr_en && !busy_q;

  logic [W-1:0] rx_next, tx_next;
  assign rx_next = lsb_first ? {din, rx_q[W-1:1]} : {rx_q[W-2:0], din};
  assign tx_next = lsb_first ? {1'b0, tx_q[W-1:1]} : {tx_q[W-2:0], 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s  <= '0;
      mosi_s <= '0;
      ss_s   <= '1;
      sck_d  <= 1'b0;
    end else begin
      sck_s  <= {sck_s[0], sck_i};
      mosi_s <= {mosi_s[0], mosi_i};
      ss_s   <= {ss_s[0], ss_n_i};
      sck_d  <= sck_s[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      hc_q   <= '0;
      edge_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      sck_q  <= cpol;
      hc_q   <= '0;
      edge_q <= '0;
    end else if (busy_q) begin
      hc_q <= m_tick ? '0 : hc_q + HW'(1);
      if (m_tick) begin
        sck_q  <= ~sck_q;
        edge_q <= edge_q + EW'(1);
        if (edge_q == EW'(2 * W - 1)) busy_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      rd_q  <= '0;
      bit_q <= '0;
    end else begin
      if (start) begin
        tx_q  <= wr_data;
        bit_q <= '0;
      end else if (!is_master && ss_s[1]) begin
        bit_q <= '0;
        if (wr_en) tx_q <= wr_data;
      end else begin
        if (!is_master && wr_en && bit_q == '0 && !setup) tx_q <= wr_data;
        if (samp) begin
          rx_q  <= rx_next;
          bit_q <= last ? '0 : bit_q + BW'(1);
          if (last) rd_q <= rx_next;
        end
        if (setup && bit_q != '0) tx_q <= tx_next;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (last) begin
      flag_q <= 1'b1;
      seen_q <= 1'b0;
    end else if (seen_q && (rd_en || wr_en)) begin
      flag_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (stat_rd && flag_q) begin
      seen_q <= 1'b1;
    end
  end

  assign rd_data   = rd_q;
  assign xfer_done = flag_q;
  assign busy_o    = busy_q;
  assign sck_o     = busy_q ? sck_q : cpol;
  assign mosi_o    = lsb_first ? tx_q[0] : tx_q[W-1];
  assign miso_o    = mosi_o;
  assign miso_oe   = slv_act;
endmodule

// File: rtl/spi_shift_unit_chk.sv
module spi_shift_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic is_master,
  input logic cpol,
  input logic wr_en,
  input logic rd_en,
  input logic ss_n_i,
  input logic busy_o,
  input logic xfer_done,
  input logic sck_o,
  input logic miso_oe
);
  // R8
  oe_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> (!$past(ss_n_i, 2) && !is_master));

  // R4
  start_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(wr_en && is_master));

  // R7
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> sck_o == cpol);

  // R7
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> sck_o == cpol);

  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_done) |-> $past(rd_en || wr_en));

  // R9
  slave_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && !$past(is_master)) |-> !busy_o);
endmodule

bind spi_shift_unit spi_shift_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .is_master(is_master), .cpol(cpol),
  .wr_en(wr_en), .rd_en(rd_en), .ss_n_i(ss_n_i), .busy_o(busy_o),
  .xfer_done(xfer_done), .sck_o(sck_o), .miso_oe(miso_oe)
);

// File: tb/spi_shift_unit_tb.sv
`timescale 1ns/1ps
module spi_shift_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic is_master = 1'b1, cpol = 1'b0, cpha = 1'b0, lsb_first = 1'b0;
  logic [2:0] rate = 3'd0;
  logic wr_en = 1'b0, stat_rd = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic xfer_done, busy_o, sck_o, mosi_o, miso_i, miso_o, miso_oe;
  logic sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;
  logic inv = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign miso_i = mosi_o ^ inv;

  spi_shift_unit dut_i (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .cpol(cpol), .cpha(cpha),
    .lsb_first(lsb_first), .rate(rate), .wr_en(wr_en), .wr_data(wr_data),
    .stat_rd(stat_rd), .rd_en(rd_en), .rd_data(rd_data), .xfer_done(xfer_done),
    .busy_o(busy_o), .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i),
    .sck_i(sck_i), .mosi_i(mosi_i), .ss_n_i(ss_n_i), .miso_o(miso_o),
    .miso_oe(miso_oe)
  );

  logic mon_bits [8];
  int   mon_n = 0;
  logic sck_prev = 1'b0, busy_prev = 1'b0;
  always @(negedge clk) begin
    if (is_master && (busy_o || busy_prev) && sck_o != sck_prev) begin
      if (((sck_prev == cpol) != cpha) && mon_n < 8) begin
        mon_bits[mon_n] = mosi_o;
        mon_n = mon_n + 1;
      end
    end
    sck_prev  = sck_o;
    busy_prev = busy_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    stat_rd = (which == 0);
    rd_en   = (which == 1);
    @(negedge clk);
    stat_rd = 1'b0;
    rd_en   = 1'b0;
  endtask

  task automatic clear_flag;
    pulse(0);
    pulse(1);
  endtask

  task automatic test_reset;
    chk(xfer_done == 1'b0, "R11 flag", int'(xfer_done), 0);
    chk(busy_o == 1'b0, "R11 busy", int'(busy_o), 0);
    chk(miso_oe == 1'b0, "R11 oe", int'(miso_oe), 0);
    chk(rd_data == 8'h00, "R11 data", int'(rd_data), 0);
    chk(sck_o == cpol, "R11 sck", int'(sck_o), int'(cpol));
  endtask

  task automatic master_xfer(input logic pol, input logic pha, input logic lsb,
                             input logic [2:0] r, input logic [7:0] d,
                             input logic inv_l, input logic extra_wr);
    int n;
    int half;
    int exp_n;
    logic [7:0] exp_rx;
    clear_flag();
    @(negedge clk);
    is_master = 1'b1; cpol = pol; cpha = pha; lsb_first = lsb; rate = r; inv = inv_l;
    @(negedge clk);
    chk(sck_o == pol, "R7 idle level", int'(sck_o), int'(pol));
    mon_n = 0;
    wr_data = d;
    wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    half  = 1 << ((r == 3'd7) ? 6 : int'(r));
    exp_n = (pha ? 16 : 15) * half;
    n = 0;
    while (!xfer_done && n < 5000) begin
      if (extra_wr && n == 3) begin
        wr_data = ~d;
        wr_en = 1'b1;
      end else begin
        wr_en = 1'b0;
      end
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    wr_en = 1'b0;
    chk(n == exp_n, "R3 cycles to flag", n, exp_n);
    exp_rx = d ^ {8{inv_l}};
    chk(rd_data == exp_rx, extra_wr ? "R4 busy write ignored" : "R1 received byte",
        int'(rd_data), int'(exp_rx));
    while (busy_o) @(negedge clk);
    @(negedge clk);
    chk(sck_o == pol, "R7 idle after transfer", int'(sck_o), int'(pol));
    chk(mon_n == 8, "R7 sample edge count", mon_n, 8);
    for (int k = 0; k < 8; k++) begin
      logic eb;
      eb = lsb ? d[k] : d[7-k];
      chk(mon_bits[k] == eb, lsb ? "R2 lsb order" : "R2 msb order",
          int'(mon_bits[k]), int'(eb));
    end
    chk(xfer_done == 1'b1, "R5 flag held", int'(xfer_done), 1);
  endtask

  task automatic half_wait;
    repeat (8) @(negedge clk);
  endtask

  task automatic slave_xfer(input logic pol, input logic pha, input logic lsb,
                            input logic [2:0] r, input logic [7:0] tx,
                            input logic [7:0] rx, input int nbits);
    clear_flag();
    @(negedge clk);
    is_master = 1'b0; cpol = pol; cpha = pha; lsb_first = lsb; rate = r;
    sck_i = pol;
    half_wait();
    chk(miso_oe == 1'b0, "R8 oe off while deselected", int'(miso_oe), 0);
    wr_data = tx;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    ss_n_i = 1'b0;
    for (int k = 0; k < nbits; k++) begin
      logic mb;
      logic eb;
      mb = lsb ? rx[k] : rx[7-k];
      eb = lsb ? tx[k] : tx[7-k];
      if (!pha) begin
        mosi_i = mb;
        half_wait();
        chk(miso_oe == 1'b1, "R8 oe on while selected", int'(miso_oe), 1);
        chk(miso_o == eb, "R8 slave out bit", int'(miso_o), int'(eb));
        sck_i = ~sck_i;
        half_wait();
        sck_i = ~sck_i;
      end else begin
        sck_i = ~sck_i;
        mosi_i = mb;
        half_wait();
        chk(miso_o == eb, "R8 slave out bit", int'(miso_o), int'(eb));
        sck_i = ~sck_i;
        half_wait();
      end
    end
    half_wait();
    if (nbits == 8) begin
      chk(xfer_done == 1'b1, "R5 slave flag", int'(xfer_done), 1);
      chk(rd_data == rx, "R8 slave received byte", int'(rd_data), int'(rx));
      chk(busy_o == 1'b0, "R9 no master activity", int'(busy_o), 0);
    end
    ss_n_i = 1'b1;
    half_wait();
    chk(miso_oe == 1'b0, "R8 oe released", int'(miso_oe), 0);
    if (nbits < 8)
      chk(xfer_done == 1'b0, "R10 partial byte discarded", int'(xfer_done), 0);
  endtask

  task automatic test_flag_clear;
    master_xfer(1'b0, 1'b0, 1'b0, 3'd0, 8'h3C, 1'b0, 1'b0);
    pulse(1);
    chk(xfer_done == 1'b1, "R6 read without status", int'(xfer_done), 1);
    pulse(0);
    chk(xfer_done == 1'b1, "R6 status read alone", int'(xfer_done), 1);
    pulse(1);
    chk(xfer_done == 1'b0, "R6 cleared", int'(xfer_done), 0);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    master_xfer(1'b0, 1'b0, 1'b0, 3'd0, 8'hA5, 1'b0, 1'b0);
    master_xfer(1'b1, 1'b1, 1'b1, 3'd1, 8'h1E, 1'b1, 1'b0);
    master_xfer(1'b0, 1'b1, 1'b0, 3'd2, 8'hC3, 1'b1, 1'b0);
    master_xfer(1'b1, 1'b0, 1'b1, 3'd3, 8'h81, 1'b0, 1'b0);
    master_xfer(1'b0, 1'b0, 1'b0, 3'd6, 8'h5A, 1'b0, 1'b0);
    master_xfer(1'b0, 1'b1, 1'b1, 3'd7, 8'h96, 1'b1, 1'b0);
    master_xfer(1'b1, 1'b1, 1'b0, 3'd1, 8'h6B, 1'b0, 1'b1);
    test_flag_clear();
    slave_xfer(1'b0, 1'b0, 1'b0, 3'd0, 8'hB4, 8'h2D, 8);
    slave_xfer(1'b1, 1'b1, 1'b1, 3'd5, 8'h4E, 8'hD1, 8);
    slave_xfer(1'b1, 1'b0, 1'b1, 3'd3, 8'h77, 8'h0F, 3);
    slave_xfer(1'b1, 1'b0, 1'b1, 3'd3, 8'h39, 8'hE2, 8);
    slave_xfer(1'b0, 1'b1, 1'b0, 3'd6, 8'hF0, 8'h5C, 5);
    slave_xfer(1'b0, 1'b1, 1'b0, 3'd0, 8'h12, 8'hA7, 8);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule